// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block governs the two low-power states of a small 8-bit processor core. The core writes a power-control value over a single-cycle register-write port. Bit 0 of that value requests idle and bit 1 requests power-down. From the stored mode the block produces a core clock enable, a peripheral clock enable and the levels placed on the address-latch and program-read strobes. Everything runs from one free-running oscillator clock. The core and peripheral clocks are gated downstream through the two enables.

Idle stops only the core. The peripherals and interrupt logic keep their clock, and any enabled interrupt request brings the core back. Power-down stops both clocks. It can only be left through an enabled external interrupt pin configured as level-sensitive. That pin must be held low for a minimum number of oscillator cycles and then released. On every exit the block sends a one-cycle wake pulse to the interrupt controller, so the pending interrupt is serviced before the core resumes. A hardware reset returns the block to its power-on state from any mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After hardware reset both mode bits are clear and the block is in run mode. Run mode means `core_clk_en`=1, `periph_clk_en`=1, `addr_stb_o`=`core_addr_stb`, `prog_stb_o`=`core_prog_stb` and `wake_pulse`=0.
- R2: In run mode, a write with `wr_data` bit 1 set enters power-down, even when bit 0 is also set. A write with only bit 0 set enters idle. Writes with both bits clear leave run mode unchanged. Bits 7..2 have no effect.
- R3: In idle, `core_clk_en`=0, `periph_clk_en`=1, `addr_stb_o`=1 and `prog_stb_o`=1.
- R4: In idle, any set bit of `irq_pend` at a clock edge clears the idle bit at that edge. The outputs are back in run mode from then on.
- R5: In power-down, `core_clk_en`=0, `periph_clk_en`=0, `addr_stb_o`=0 and `prog_stb_o`=0. `irq_pend` has no effect. External pins that are disabled (`ext_en`=0) or edge-configured (`ext_level`=0) have no effect.
- R6: In power-down, the exit happens at the first edge where a qualifying pin (enabled, level-configured) has been low for at least HOLD_CYC consecutive edges and no qualifying pin is low any more. A pin released earlier leaves the block in power-down and restarts the count from zero. A pin that is still held low does not cause an exit.
- R7: A hardware reset in idle or power-down clears both mode bits at once and restores the R1 state.
- R8: `wake_pulse` is high for exactly one cycle, in the cycle after an idle or power-down exit. It is never high otherwise, including when `irq_pend` is active in run mode.
- R9: Writes arriving while in idle or power-down are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe for the power-control register |
| wr_data | input | DW (8) | Write value; bit 0 requests idle, bit 1 requests power-down |
| irq_pend | input | NUM_IRQ (4) | Enabled interrupt requests, already masked |
| ext_pin_n | input | NUM_EXT (2) | External interrupt pins, active low |
| ext_en | input | NUM_EXT (2) | Enable for each external pin |
| ext_level | input | NUM_EXT (2) | 1 = pin configured level-sensitive |
| core_addr_stb | input | 1 | Address-latch strobe from the core in run mode |
| core_prog_stb | input | 1 | Program-read strobe from the core in run mode |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| addr_stb_o | output | 1 | Address-latch strobe level at the pin |
| prog_stb_o | output | 1 | Program-read strobe level at the pin |
| wake_pulse | output | 1 | One-cycle notice to the interrupt controller on exit |

## Verification
Several rules are checked by assertions on every cycle:
- the two mode bits are never set together;
- an idle bit with a pending request always clears with a wake pulse;
- the wake pulse never lasts two cycles;
- mode writes outside run mode change nothing;
- the hold counter clears when the pin releases;
- every fall of power-down was preceded by a full hold count.

Other behaviour only the bench scenarios can show:
- the pin levels in each mode;
- the priority of power-down over idle;
- the ignored upper data bits;
- the rejection of edge-configured and disabled pins;
- the exact boundary between HOLD_CYC-1 and HOLD_CYC held cycles;
- a split hold that adds up past the limit but still fails;
- reset out of each mode.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_DOWN = 2'd2
   } pm_mode_t;

   localparam int IDLE_BIT = 0;
   localparam int DOWN_BIT = 1;
endpackage

// File: rtl/pmc_mode_reg.sv
module pmc_mode_reg
   import pmc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          idle_wake,
   input  logic          down_wake,
   output pm_mode_t      mode,
   output logic          wake_pulse
);
   logic idl_q, pd_q;

   initial begin
      assert (DW > DOWN_BIT) else $error("DW too narrow for mode bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idl_q      <= 1'b0;
         pd_q       <= 1'b0;
         wake_pulse <= 1'b0;
      end else begin
         wake_pulse <= 1'b0;
         if (!idl_q && !pd_q) begin
            if (wr_en) begin
               if (wr_data[DOWN_BIT])      pd_q  <= 1'b1;
               else if (wr_data[IDLE_BIT]) idl_q <= 1'b1;
            end
         end else if (pd_q) begin
            if (down_wake) begin
               pd_q       <= 1'b0;
               wake_pulse <= 1'b1;
            end
         end else if (idle_wake) begin
            idl_q      <= 1'b0;
            wake_pulse <= 1'b1;
         end
      end
   end

   always_comb mode = pd_q ? PM_DOWN : (idl_q ? PM_IDLE : PM_RUN);

   // R2: power-down wins, the two bits never coexist
   p_one_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(idl_q && pd_q));
   // R4: pending request in idle always leaves idle with a pulse
   p_idle_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (idl_q && idle_wake) |=> (!idl_q && wake_pulse));
   // R8: pulse lasts a single cycle
   p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);
   // R9: writes outside run mode change nothing
   p_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((idl_q || pd_q) && wr_en && !idle_wake && !down_wake)
      |=> $stable({idl_q, pd_q}));
endmodule

// File: rtl/pmc_wake_timer.sv
module pmc_wake_timer #(
   parameter int HOLD_CYC = 1024,
   parameter int NUM_EXT  = 2,
   parameter int EXT_SYNC = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               armed,
   input  logic [NUM_EXT-1:0] pin_n,
   input  logic [NUM_EXT-1:0] pin_en,
   input  logic [NUM_EXT-1:0] pin_level,
   output logic               held,
   output logic               wake_ok
);
   localparam int CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

   logic [NUM_EXT-1:0] pin_s;
   logic [NUM_EXT-1:0] qual;
   logic               src;
   logic [CW-1:0]      cnt;

   initial begin
      assert (HOLD_CYC >= 1) else $error("HOLD_CYC must be at least 1");
      assert (NUM_EXT >= 1)  else $error("NUM_EXT must be at least 1");
      assert (EXT_SYNC >= 0 && EXT_SYNC <= 3) else $error("EXT_SYNC out of range");
   end

   generate
      if (EXT_SYNC == 0) begin : g_direct
         assign pin_s = pin_n;
      end else begin : g_sync
         logic [NUM_EXT-1:0] stg [EXT_SYNC];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < EXT_SYNC; i++) stg[i] <= '1;
            end else begin
               stg[0] <= pin_n;
               for (int i = 1; i < EXT_SYNC; i++) stg[i] <= stg[i-1];
            end
         end
         assign pin_s = stg[EXT_SYNC-1];
      end
   endgenerate

   for (genvar k = 0; k < NUM_EXT; k++) begin : g_qual
      assign qual[k] = pin_en[k] & pin_level[k] & ~pin_s[k];
   end

   assign src = |qual;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!armed || !src)   cnt <= '0;
      else if (cnt != LIMIT)     cnt <= cnt + 1'b1;
   end

   assign held    = (cnt == LIMIT);
   assign wake_ok = armed && held && !src;

   // R6: a released pin always restarts the hold count
   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !src) |=> (cnt == '0));
   // R6: count never runs past its limit
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIMIT);
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
   import pmc_pkg::*;
(
   input  pm_mode_t mode,
   input  logic     core_addr_stb,
   input  logic     core_prog_stb,
   output logic     core_clk_en,
   output logic     periph_clk_en,
   output logic     addr_stb_o,
   output logic     prog_stb_o
);
   always_comb begin
      case (mode)
         PM_IDLE: begin
            core_clk_en   = 1'b0;
            periph_clk_en = 1'b1;
            addr_stb_o    = 1'b1;
            prog_stb_o    = 1'b1;
         end
         PM_DOWN: begin
            core_clk_en   = 1'b0;
            periph_clk_en = 1'b0;
            addr_stb_o    = 1'b0;
            prog_stb_o    = 1'b0;
         end
         default: begin
            core_clk_en   = 1'b1;
            periph_clk_en = 1'b1;
            addr_stb_o    = core_addr_stb;
            prog_stb_o    = core_prog_stb;
         end
      endcase
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int DW       = 8,
   parameter int NUM_IRQ  = 4,
   parameter int NUM_EXT  = 2,
   parameter int HOLD_CYC = 1024,
   parameter int EXT_SYNC = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DW-1:0]      wr_data,
   input  logic [NUM_IRQ-1:0] irq_pend,
   input  logic [NUM_EXT-1:0] ext_pin_n,
   input  logic [NUM_EXT-1:0] ext_en,
   input  logic [NUM_EXT-1:0] ext_level,
   input  logic               core_addr_stb,
   input  logic               core_prog_stb,
   output logic               core_clk_en,
   output logic               periph_clk_en,
   output logic               addr_stb_o,
   output logic               prog_stb_o,
   output logic               wake_pulse
);
   pm_mode_t mode;
   logic     held, down_wake, pd_state;

   initial begin
      assert (NUM_IRQ >= 1) else $error("NUM_IRQ must be at least 1");
   end

   assign pd_state = (mode == PM_DOWN);

   pmc_mode_reg #(.DW(DW)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .idle_wake  (|irq_pend),
      .down_wake  (down_wake),
      .mode       (mode),
      .wake_pulse (wake_pulse)
   );

   pmc_wake_timer #(
      .HOLD_CYC (HOLD_CYC),
      .NUM_EXT  (NUM_EXT),
      .EXT_SYNC (EXT_SYNC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (pd_state),
      .pin_n     (ext_pin_n),
      .pin_en    (ext_en),
      .pin_level (ext_level),
      .held      (held),
      .wake_ok   (down_wake)
   );

   pmc_clk_gate u_gate (
      .mode          (mode),
      .core_addr_stb (core_addr_stb),
      .core_prog_stb (core_prog_stb),
      .core_clk_en   (core_clk_en),
      .periph_clk_en (periph_clk_en),
      .addr_stb_o    (addr_stb_o),
      .prog_stb_o    (prog_stb_o)
   );

   // R6: leaving power-down always follows a completed hold count
   p_pd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_state) |-> $past(held));
   // R5: with both clocks stopped, the wake pulse only follows a full hold
   p_pd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_state && !held) |=> !wake_pulse);
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
   localparam int HOLD = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [3:0] irq_pend = '0;
   logic [1:0] ext_pin_n = 2'b11;
   logic [1:0] ext_en = 2'b11;
   logic [1:0] ext_level = 2'b01;
   logic       core_addr_stb = 1'b0;
   logic       core_prog_stb = 1'b1;
   logic       core_clk_en, periph_clk_en, addr_stb_o, prog_stb_o, wake_pulse;

   int total = 0;
   int bad = 0;

   pwr_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .irq_pend(irq_pend), .ext_pin_n(ext_pin_n), .ext_en(ext_en),
      .ext_level(ext_level), .core_addr_stb(core_addr_stb),
      .core_prog_stb(core_prog_stb), .core_clk_en(core_clk_en),
      .periph_clk_en(periph_clk_en), .addr_stb_o(addr_stb_o),
      .prog_stb_o(prog_stb_o), .wake_pulse(wake_pulse)
   );

   always #4 clk = ~clk;

   // {data, expected mode: 0 run, 1 idle, 2 power-down}
   localparam logic [9:0] VEC [7] = '{
      {8'h01, 2'd1}, {8'h02, 2'd2}, {8'h03, 2'd2}, {8'h00, 2'd0},
      {8'hFD, 2'd1}, {8'hFC, 2'd0}, {8'hFE, 2'd2}
   };

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] outs_for(int m);
      if (m == 1)      return 4'b0111;
      else if (m == 2) return 4'b0000;
      else             return {2'b11, core_addr_stb, core_prog_stb};
   endfunction

   task automatic chk_mode(string tag, int m);
      chk(tag, {28'd0, core_clk_en, periph_clk_en, addr_stb_o, prog_stb_o},
          {28'd0, outs_for(m)});
   endtask

   task automatic do_write(logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic hw_reset();
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic irq_exit(string tag);
      irq_pend = 4'b0100;
      @(negedge clk);
      irq_pend = '0;
      chk_mode({tag, " R4 mode after irq"}, 0);
      chk({tag, " R8 pulse high"}, {31'd0, wake_pulse}, 32'd1);
      @(negedge clk);
      chk({tag, " R8 pulse gone"}, {31'd0, wake_pulse}, 32'd0);
   endtask

   // hold pin k low for n edges, release, step one edge
   task automatic hold_pin(int k, int n);
      ext_pin_n[k] = 1'b0;
      repeat (n) @(negedge clk);
      ext_pin_n[k] = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 8);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_mode("R1 in reset", 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_mode("R1 after reset", 0);
      chk("R1 no pulse", {31'd0, wake_pulse}, 32'd0);
      core_addr_stb = 1'b1; core_prog_stb = 1'b0;
      #1;
      chk_mode("R1 strobe passthrough", 0);

      // table walk: R2 R3 R5 entry patterns
      for (int i = 0; i < 7; i++) begin
         do_write(VEC[i][9:2]);
         chk_mode($sformatf("R2 R3 R5 vec%0d", i), int'(VEC[i][1:0]));
         if (VEC[i][1:0] == 2'd1) irq_exit($sformatf("vec%0d", i));
         else if (VEC[i][1:0] == 2'd2) begin
            hw_reset();
            chk_mode($sformatf("R7 reset from pd vec%0d", i), 0);
         end
      end

      // R8: requests in run mode give no pulse
      irq_pend = 4'b1111;
      repeat (2) @(negedge clk);
      chk("R8 no pulse in run", {31'd0, wake_pulse}, 32'd0);
      chk_mode("R8 run stays run", 0);
      irq_pend = '0;

      // R9: writes ignored in idle
      do_write(8'h01);
      do_write(8'h02);
      chk_mode("R9 idle keeps idle", 1);
      chk("R9 no pulse", {31'd0, wake_pulse}, 32'd0);
      irq_exit("R9");

      // R7: reset from idle
      do_write(8'h01);
      hw_reset();
      chk_mode("R7 reset from idle", 0);
      chk("R7 no pulse", {31'd0, wake_pulse}, 32'd0);

      // R5: power-down ignores requests and unqualified pins
      do_write(8'h02);
      irq_pend = 4'b1111;
      repeat (3) @(negedge clk);
      irq_pend = '0;
      @(negedge clk);
      chk_mode("R5 irq ignored", 2);
      hold_pin(1, HOLD + 5);
      chk_mode("R5 edge pin ignored", 2);
      ext_en = 2'b10;
      hold_pin(0, HOLD + 5);
      chk_mode("R5 disabled pin ignored", 2);
      do_write(8'h00);
      chk_mode("R9 write in pd ignored", 2);
      ext_en = 2'b11;

      // R6: boundary and restart
      hold_pin(0, HOLD - 1);
      chk_mode("R6 short hold stays", 2);
      chk("R6 short no pulse", {31'd0, wake_pulse}, 32'd0);
      hold_pin(0, 2);
      chk_mode("R6 split hold stays", 2);
      ext_pin_n[0] = 1'b0;
      repeat (HOLD + 10) @(negedge clk);
      chk_mode("R6 still held stays", 2);
      ext_pin_n[0] = 1'b1;
      @(negedge clk);
      chk_mode("R6 long hold exits", 0);
      chk("R6 R8 pulse", {31'd0, wake_pulse}, 32'd1);
      @(negedge clk);
      chk("R8 pulse one cycle", {31'd0, wake_pulse}, 32'd0);

      do_write(8'h02);
      hold_pin(0, HOLD);
      chk_mode("R6 exact hold exits", 0);
      chk("R6 exact pulse", {31'd0, wake_pulse}, 32'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule